// File: doc/BRIEF.md
# Per-Line Dead Block Predictor

This block tracks how recently each line of a data cache has been used and raises a dead flag for every line that has gone unused for a programmable stretch of time. Replacement logic reads the flag vector to choose which lines can be given up to hold replicas or new data. Each line carries a two-bit saturating age counter. A shared coarse tick advances every valid line's counter. Any access to a line clears its counter.

The decay window is a cycle count supplied on an input. The internal tick period is one third of that window, and never less than one cycle. A line left untouched for a full window therefore saturates its counter and reads as dead. A window of zero selects an aggressive mode: a line reads dead as soon as the access or fill that touched it has completed. Filling a line starts it fresh. Invalidating a line makes it read dead. Lines that hold nothing always read dead.

Top module: `dead_line_predictor`

## Requirements
- R1: While reset is high and on the first edge after it, every line is invalid and every bit of `dead_vec` is 1.
- R2: In window mode (window not zero), a fill of a line makes it valid with age 0, so its `dead_vec` bit is 0 after that edge.
- R3: A tick occurs every max(1, floor(window/3)) cycles, counted from reset. Each tick raises the age of every valid line by one and holds it at 3 once it reaches 3.
- R4: A valid line's `dead_vec` bit is 1 exactly when its age is 3. A line filled or accessed and then left alone reads 0 for at least 2*P-1 cycles and 1 within 3*P cycles, where P is the tick period.
- R5: In window mode, an access to a valid line sets its age to 0. When an access and a tick land in the same cycle, the access wins.
- R6: An invalidate makes the line invalid, and its bit reads 1. On the same line in the same cycle, invalidate wins over fill and access, and fill wins over access.
- R7: An access to an invalid line has no effect, and its bit stays 1.
- R8: With window equal to 0, a fill or an access to a valid line leaves that line's bit at 1 after the edge, and ticks are suppressed.
- R9: `dead_vec` is registered. It reflects all events applied at an edge right after that edge, and it does not change between edges.
- R10: Access, fill and invalidate strobes that name different lines in the same cycle all take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| decay_win | input | WIN_W | Decay window in cycles; 0 selects aggressive mode |
| acc_vld | input | 1 | Access strobe |
| acc_idx | input | IDX_W | Line index of the access |
| fill_vld | input | 1 | Fill strobe |
| fill_idx | input | IDX_W | Line index of the fill |
| inv_vld | input | 1 | Invalidate strobe |
| inv_idx | input | IDX_W | Line index of the invalidate |
| dead_vec | output | NUM_LINES | One dead flag per line |

## Verification
A wrong age counter in one line shows up only on that line's bit of `dead_vec`. It appears as a flag that rises one tick period too early or too late, or that never rises at all. A fault can therefore hide for up to three tick periods after the last touch. The bench walks a fixed event schedule with a short period, so that every tick edge is observed. A broken tick divider or a broken event priority shows up within one or two periods as a bit differing from the hand-derived vector. Long-window bounds check that the age does not advance early.

// File: rtl/dlp_pkg.sv
package dlp_pkg;
  typedef logic [1:0] age_t;
  localparam age_t AGE_SAT = 2'd3;

  // Tick period: one third of the window, at least one cycle.
  function automatic logic [31:0] tick_period(input logic [31:0] win);
    logic [31:0] p;
    p = win / 32'd3;
    return (p == 32'd0) ? 32'd1 : p;
  endfunction
endpackage

// File: rtl/dlp_tick_gen.sv
module dlp_tick_gen #(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIN_W-1:0] decay_win,
  output logic             aggr,
  output logic             tick
);
  import dlp_pkg::*;

  logic [WIN_W-1:0] period_q;
  logic [WIN_W-1:0] phase_q;
  logic             wrap;

  // Register the divided window so the divider stays off the tick path.
  always_ff @(posedge clk) begin
    period_q <= WIN_W'(tick_period(32'(decay_win)));
  end

  assign wrap = (phase_q >= period_q - WIN_W'(1));
  assign aggr = (decay_win == '0);
  assign tick = wrap && !aggr;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (wrap) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + WIN_W'(1);
    end
  end

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && period_q > WIN_W'(1) && $stable(decay_win)) |=> !tick);

  // R3
  phase_restart_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (phase_q == '0));
endmodule

// File: rtl/dlp_event_decode.sv
module dlp_event_decode #(
  parameter int NUM_LINES = 256,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                 acc_vld,
  input  logic [IDX_W-1:0]     acc_idx,
  input  logic                 fill_vld,
  input  logic [IDX_W-1:0]     fill_idx,
  input  logic                 inv_vld,
  input  logic [IDX_W-1:0]     inv_idx,
  output logic [NUM_LINES-1:0] acc_hit,
  output logic [NUM_LINES-1:0] fill_hit,
  output logic [NUM_LINES-1:0] inv_hit
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_dec
    assign acc_hit[g]  = acc_vld  && (acc_idx  == IDX_W'(g));
    assign fill_hit[g] = fill_vld && (fill_idx == IDX_W'(g));
    assign inv_hit[g]  = inv_vld  && (inv_idx  == IDX_W'(g));
  end
endmodule

// File: rtl/dlp_line_cell.sv
module dlp_line_cell (
  input  logic clk,
  input  logic rst,
  input  logic aggr,
  input  logic tick,
  input  logic acc_hit,
  input  logic fill_hit,
  input  logic inv_hit,
  output logic dead
);
  import dlp_pkg::*;

  logic valid_q, valid_n;
  age_t age_q, age_n;
  logic dead_q;

  always_comb begin
    valid_n = valid_q;
    age_n   = age_q;
    if (inv_hit) begin
      valid_n = 1'b0;
      age_n   = '0;
    end else if (fill_hit) begin
      valid_n = 1'b1;
      age_n   = aggr ? AGE_SAT : age_t'(0);
    end else if (acc_hit && valid_q) begin
      age_n   = aggr ? AGE_SAT : age_t'(0);
    end else if (tick && valid_q && age_q != AGE_SAT) begin
      age_n   = age_q + age_t'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      age_q   <= '0;
      dead_q  <= 1'b1;
    end else begin
      valid_q <= valid_n;
      age_q   <= age_n;
      dead_q  <= !valid_n || (age_n == AGE_SAT);
    end
  end

  assign dead = dead_q;

  // R6
  inv_kills_chk: assert property (@(posedge clk) disable iff (rst)
    inv_hit |=> dead_q);

  // R5
  touch_revives_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_hit && valid_q && !inv_hit && !aggr) |=> !dead_q);

  // R8
  aggr_dead_chk: assert property (@(posedge clk) disable iff (rst)
    (aggr && !inv_hit && (fill_hit || (acc_hit && valid_q))) |=> dead_q);

  // R3
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && age_q == AGE_SAT && !inv_hit && !fill_hit && !acc_hit)
      |=> (age_q == AGE_SAT));

  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !inv_hit && !fill_hit && !acc_hit)
      |=> (age_q == $past(age_q) || age_q == $past(age_q) + age_t'(1)));

  // R7
  idle_invalid_chk: assert property (@(posedge clk) disable iff (rst)
    (!valid_q && !fill_hit) |=> dead_q);
endmodule

// File: rtl/dead_line_predictor.sv
module dead_line_predictor #(
  parameter int NUM_LINES = 256,
  parameter int WIN_W = 16,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [WIN_W-1:0]     decay_win,
  input  logic                 acc_vld,
  input  logic [IDX_W-1:0]     acc_idx,
  input  logic                 fill_vld,
  input  logic [IDX_W-1:0]     fill_idx,
  input  logic                 inv_vld,
  input  logic [IDX_W-1:0]     inv_idx,
  output logic [NUM_LINES-1:0] dead_vec
);
  logic                 aggr;
  logic                 tick;
  logic [NUM_LINES-1:0] acc_hit;
  logic [NUM_LINES-1:0] fill_hit;
  logic [NUM_LINES-1:0] inv_hit;

  dlp_tick_gen #(.WIN_W(WIN_W)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .decay_win(decay_win),
    .aggr     (aggr),
    .tick     (tick)
  );

  dlp_event_decode #(.NUM_LINES(NUM_LINES)) u_dec (
    .acc_vld (acc_vld),
    .acc_idx (acc_idx),
    .fill_vld(fill_vld),
    .fill_idx(fill_idx),
    .inv_vld (inv_vld),
    .inv_idx (inv_idx),
    .acc_hit (acc_hit),
    .fill_hit(fill_hit),
    .inv_hit (inv_hit)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    dlp_line_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .aggr    (aggr),
      .tick    (tick),
      .acc_hit (acc_hit[g]),
      .fill_hit(fill_hit[g]),
      .inv_hit (inv_hit[g]),
      .dead    (dead_vec[g])
    );
  end

  // R1
  reset_all_dead_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (dead_vec == '1));

  // R9
  no_midcycle_change_chk: assert property (@(posedge clk) disable iff (rst)
    (!acc_vld && !fill_vld && !inv_vld && !tick) |=> $stable(dead_vec));
endmodule

// File: tb/dead_line_predictor_tb.sv
`timescale 1ns/1ps
module dead_line_predictor_tb;
  localparam int NL = 8;
  localparam int WW = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [WW-1:0] decay_win = 8'd6;
  logic          acc_vld = 1'b0, fill_vld = 1'b0, inv_vld = 1'b0;
  logic [IW-1:0] acc_idx = '0, fill_idx = '0, inv_idx = '0;
  logic [NL-1:0] dead_vec;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dead_line_predictor #(.NUM_LINES(NL), .WIN_W(WW)) u_dut (
    .clk(clk), .rst(rst), .decay_win(decay_win),
    .acc_vld(acc_vld), .acc_idx(acc_idx),
    .fill_vld(fill_vld), .fill_idx(fill_idx),
    .inv_vld(inv_vld), .inv_idx(inv_idx),
    .dead_vec(dead_vec)
  );

  // op: 0 idle, 1 access, 2 fill, 3 invalidate; window 6 gives a tick on every 2nd edge
  typedef struct packed { logic [1:0] op; logic [2:0] idx; logic [7:0] exp; } vec_t;
  localparam vec_t VECS [20] = '{
    '{2'd2, 3'd0, 8'hFE}, '{2'd2, 3'd1, 8'hFC}, '{2'd2, 3'd2, 8'hF8}, '{2'd0, 3'd0, 8'hF8},
    '{2'd1, 3'd1, 8'hF8}, '{2'd0, 3'd0, 8'hF9}, '{2'd1, 3'd0, 8'hF8}, '{2'd1, 3'd2, 8'hF8},
    '{2'd3, 3'd1, 8'hFA}, '{2'd1, 3'd1, 8'hFA}, '{2'd0, 3'd0, 8'hFA}, '{2'd0, 3'd0, 8'hFB},
    '{2'd2, 3'd1, 8'hF9}, '{2'd0, 3'd0, 8'hFD}, '{2'd0, 3'd0, 8'hFD}, '{2'd0, 3'd0, 8'hFD},
    '{2'd0, 3'd0, 8'hFD}, '{2'd0, 3'd0, 8'hFF}, '{2'd1, 3'd1, 8'hFD}, '{2'd3, 3'd0, 8'hFD}
  };

  task automatic check(input string req, input logic [NL-1:0] act, input logic [NL-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: dead_vec actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_bit(input string req, input int line, input logic exp);
    n_vec++;
    if (dead_vec[line] !== exp) begin
      n_bad++;
      $display("FAIL %s: line %0d actual %b expected %b", req, line, dead_vec[line], exp);
    end
  endtask

  task automatic clear_strobes();
    acc_vld = 1'b0; fill_vld = 1'b0; inv_vld = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", dead_vec, 8'hFF);
    rst = 1'b0;
    // R2 R3 R4 R5 R6 R7 R9: scheduled table
    for (int i = 0; i < 20; i++) begin
      clear_strobes();
      case (VECS[i].op)
        2'd1: begin acc_vld = 1'b1;  acc_idx = VECS[i].idx;  end
        2'd2: begin fill_vld = 1'b1; fill_idx = VECS[i].idx; end
        2'd3: begin inv_vld = 1'b1;  inv_idx = VECS[i].idx;  end
        default: ;
      endcase
      step();
      check($sformatf("R3/R4/R5 table step %0d", i), dead_vec, VECS[i].exp);
    end
    clear_strobes();

    // R8: aggressive mode, fill reads dead at once
    decay_win = 8'd0;
    fill_vld = 1'b1; fill_idx = 3'd3;
    step(); clear_strobes();
    check_bit("R8 fill in aggressive mode", 3, 1'b1);
    acc_vld = 1'b1; acc_idx = 3'd3;
    step(); clear_strobes();
    check_bit("R8 access in aggressive mode", 3, 1'b1);

    // R5 R4: window 3 gives a tick every edge; access wins over tick
    decay_win = 8'd3;
    acc_vld = 1'b1; acc_idx = 3'd1;
    step(); clear_strobes();
    check_bit("R5 access beats tick", 1, 1'b0);
    step(); check_bit("R4 age 1", 1, 1'b0);
    step(); check_bit("R4 age 2", 1, 1'b0);
    step(); check_bit("R4 age 3 dead", 1, 1'b1);

    // R6: invalidate beats fill on same line
    fill_vld = 1'b1; fill_idx = 3'd4;
    step(); clear_strobes();
    check_bit("R2 fill clears dead", 4, 1'b0);
    fill_vld = 1'b1; fill_idx = 3'd4; inv_vld = 1'b1; inv_idx = 3'd4;
    step(); clear_strobes();
    check_bit("R6 invalidate beats fill", 4, 1'b1);

    // R10: strobes on different lines in one cycle
    fill_vld = 1'b1; fill_idx = 3'd6; acc_vld = 1'b1; acc_idx = 3'd1;
    inv_vld = 1'b1; inv_idx = 3'd2;
    step(); clear_strobes();
    check("R10 parallel events", dead_vec & 8'b0100_0110, 8'b0000_0100);

    // R1: reset mid-run
    rst = 1'b1;
    step(); step();
    check("R1 reset mid-run", dead_vec, 8'hFF);

    // R4: long window, period 85, bounds independent of phase
    decay_win = 8'd255;
    step(); step();
    rst = 1'b0;
    fill_vld = 1'b1; fill_idx = 3'd5;
    step(); clear_strobes();
    check_bit("R2 fill long window", 5, 1'b0);
    for (int k = 0; k < 169; k++) step();
    check_bit("R4 alive before 2P-1 cycles", 5, 1'b0);
    for (int k = 0; k < 86; k++) step();
    check_bit("R4 dead within 3P cycles", 5, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule